// File: doc/BRIEF.md
# Binary32 Rounding and Packing Stage

This block turns an intermediate single-precision result into a finished binary32 word. The intermediate value comes in three parts: a sign bit, a signed exponent, and a 31-bit significand. The significand has its binary point between bits 30 and 29, and seven extra rounding bits hang below the normal fraction. A 2-bit mode input chooses the rounding direction.

The stage handles three kinds of result:
- **Overflow:** the result saturates to infinity or to the largest finite magnitude.
- **Tiny values:** the significand is shifted right with sticky jamming, so the result is a subnormal.
- **All results:** the stage reports inexact, overflow and underflow flags.

The fields are joined by binary addition, not by OR. A carry out of the rounded significand therefore moves the exponent up by one.

Values arrive on a valid/ready stream and leave on another one. The block has a single output register. An input is taken on any cycle where `in_valid` and `in_ready` are both high. Its result and flags are on the output one cycle later, with `out_valid` high. `in_ready` is high when the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the word and the flags stay frozen and no new input is taken. Once an input has been offered, the producer may not change it until it is taken.

Top module: `f32_round_pack`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An input taken at a clock edge raises `out_valid` at that same edge, with its result. While `out_valid` is high and `out_ready` is low, `out_word` and all flags hold their values.
- R2: The significand binary point sits between bits 30 and 29, and bits 6..0 are the rounding bits. For a normalized significand, the exponent input is one less than the true exponent. The output word is `(sign<<31) + (exp<<23) + rounded`, a 32-bit sum, so a rounding carry increments the exponent.
- R3: Mode 0 (nearest-even) adds 0x40 to the significand before the 7-bit right shift. When the rounding bits are exactly 0x40, bit 0 of the result is cleared.
- R4: Mode 1 (toward zero) adds nothing, so the rounding bits are simply dropped.
- R5: Mode 2 (toward +inf) adds 0x7F for positive values and 0 for negative values. Mode 3 (toward -inf) adds 0x7F for negative values and 0 for positive values.
- R6: Overflow is detected when the exponent is above 253, or when it equals 253 and significand + increment carries into bit 31. The result is then signed infinity (magnitude 0x7F800000), or 0x7F7FFFFF when the increment is 0. Both the overflow and inexact flags are set.
- R7: A negative exponent shifts the significand right by its magnitude, ORing any lost 1 bits into bit 0. The rounding bits are then taken from the shifted value and the exponent is treated as 0. Underflow is flagged only in this case, and only when those rounding bits are nonzero.
- R8: A shift of 31 or more leaves only the sticky bit: 1 if the input significand was nonzero, else 0.
- R9: When the rounded significand is zero, the exponent field is forced to 0, leaving a signed zero.
- R10: Inexact is set exactly when the rounding bits that were used are nonzero, or on overflow. A result that needs no rounding raises no flag.
- R11: During reset, `out_valid`, `out_word` and all flags are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Stage can take an input this cycle |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Signed exponent, one below the true exponent |
| in_sig | input | 31 | Significand with 7 low rounding bits |
| in_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed binary32 result |
| out_inexact | output | 1 | Result was rounded or saturated |
| out_overflow | output | 1 | Result overflowed |
| out_underflow | output | 1 | Tiny result that was also inexact |

## Verification
The rounding path is driven with several kinds of significand:
- **Exact, tie and just-above-tie patterns in each mode:** these separate the four increments and the even-clearing rule.
- **All-ones rounding bits near a binade edge:** this shows the carry rippling into the exponent, both for normal values and for a subnormal that rounds up to the smallest normal.
- **Exponents at 253 and 254:** these separate the carry-induced overflow from the plain one, and infinity from the largest finite value.
- **Small, medium and very large negative exponents:** these tell jammed shifting apart from the sticky-only case, and show whether underflow follows the inexact condition.

A pseudo-random sweep is run with the consumer stalling on two cycles out of three. This exercises the hold rule and the ready relation together with the arithmetic.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int FRAC_W   = 23;
  localparam int EXPF_W   = 8;
  localparam int GRD_W    = 7;
  localparam int SIG_W    = FRAC_W + 1 + GRD_W;
  localparam int WORD_W   = 1 + EXPF_W + FRAC_W;
  localparam int RQ_W     = SIG_W + 1 - GRD_W;
  localparam int EMAX_OVF = (1 << EXPF_W) - 3;

  localparam logic [GRD_W-1:0] INC_HALF = GRD_W'(1) << (GRD_W - 1);
  localparam logic [GRD_W-1:0] INC_FULL = '1;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_ZERO      = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rmode_e;
endpackage

// File: rtl/rp_incr.sv
module rp_incr
  import rp_pkg::*;
(
  input  rmode_e             mode,
  input  logic               sign,
  output logic [GRD_W-1:0]   inc
);
  always_comb begin
    unique case (mode)
      RM_NEAR_EVEN: inc = INC_HALF;
      RM_ZERO:      inc = '0;
      RM_UP:        inc = sign ? '0 : INC_FULL;
      RM_DOWN:      inc = sign ? INC_FULL : '0;
      default:      inc = '0;
    endcase
  end
endmodule

// File: rtl/rp_denorm.sv
module rp_denorm
  import rp_pkg::*;
#(
  parameter int SH_W = 10
) (
  input  logic [SIG_W-1:0] sig,
  input  logic [SH_W-1:0]  shamt,
  output logic [SIG_W-1:0] jam
);
  logic [SIG_W-1:0] kept_mask;
  logic [SIG_W-1:0] shifted;
  logic             lost;

  always_comb begin
    shifted   = sig >> shamt;
    kept_mask = {SIG_W{1'b1}} << shamt;
    lost      = |(sig & ~kept_mask);
    jam       = shifted | {{(SIG_W-1){1'b0}}, lost};
  end
endmodule

// File: rtl/rp_pack.sv
module rp_pack
  import rp_pkg::*;
(
  input  logic              sign,
  input  logic [EXPF_W-1:0] exp_eff,
  input  logic [SIG_W-1:0]  sig_eff,
  input  logic [GRD_W-1:0]  inc,
  input  logic              near_even,
  output logic [WORD_W-1:0] word,
  output logic              rbits_nz
);
  logic [GRD_W-1:0]  rbits;
  logic [SIG_W:0]    sum;
  logic [RQ_W-1:0]   rq;
  logic [RQ_W-1:0]   rq_fin;
  logic              tie;
  logic [EXPF_W-1:0] ef;

  always_comb begin
    rbits    = sig_eff[GRD_W-1:0];
    rbits_nz = |rbits;
    sum      = {1'b0, sig_eff} + (SIG_W+1)'(inc);
    rq       = sum[SIG_W:GRD_W];
    tie      = near_even && (rbits == INC_HALF);
    rq_fin   = {rq[RQ_W-1:1], rq[0] & ~tie};
    ef       = (rq_fin == '0) ? '0 : exp_eff;
    word     = {sign, {(WORD_W-1){1'b0}}}
             + (WORD_W'(ef) << FRAC_W)
             + WORD_W'(rq_fin);
  end
endmodule

// File: rtl/f32_round_pack.sv
module f32_round_pack
  import rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [30:0]             in_sig,
  input  logic [1:0]              in_mode,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [31:0]             out_word,
  output logic                    out_inexact,
  output logic                    out_overflow,
  output logic                    out_underflow
);
  localparam logic signed [EXP_W-1:0] OVF_E = EXP_W'(EMAX_OVF);

  rmode_e            mode;
  logic [GRD_W-1:0]  inc;
  logic              neg_exp;
  logic [EXP_W-1:0]  shamt;
  logic [SIG_W-1:0]  jam;
  logic [SIG_W-1:0]  sig_eff;
  logic [EXPF_W-1:0] exp_eff;
  logic [SIG_W:0]    ovf_sum;
  logic              ovf;
  logic [WORD_W-1:0] packed_w;
  logic              rbits_nz;
  logic [WORD_W-1:0] nxt_word;
  logic              nxt_inx, nxt_ovf, nxt_unf;
  logic              take;

  assign mode = rmode_e'(in_mode);

  rp_incr u_incr (
    .mode (mode),
    .sign (in_sign),
    .inc  (inc)
  );

  assign neg_exp = in_exp[EXP_W-1];
  assign shamt   = EXP_W'(-in_exp);

  rp_denorm #(.SH_W(EXP_W)) u_denorm (
    .sig   (in_sig),
    .shamt (shamt),
    .jam   (jam)
  );

  always_comb begin
    sig_eff = neg_exp ? jam : in_sig;
    exp_eff = neg_exp ? '0 : in_exp[EXPF_W-1:0];
    ovf_sum = {1'b0, in_sig} + (SIG_W+1)'(inc);
    ovf     = (in_exp > OVF_E) || ((in_exp == OVF_E) && ovf_sum[SIG_W]);
  end

  rp_pack u_pack (
    .sign      (in_sign),
    .exp_eff   (exp_eff),
    .sig_eff   (sig_eff),
    .inc       (inc),
    .near_even (mode == RM_NEAR_EVEN),
    .word      (packed_w),
    .rbits_nz  (rbits_nz)
  );

  always_comb begin
    if (ovf) begin
      nxt_word = {in_sign, (inc == '0) ? 31'h7F7F_FFFF : 31'h7F80_0000};
      nxt_inx  = 1'b1;
      nxt_ovf  = 1'b1;
      nxt_unf  = 1'b0;
    end else begin
      nxt_word = packed_w;
      nxt_inx  = rbits_nz;
      nxt_ovf  = 1'b0;
      nxt_unf  = neg_exp && rbits_nz;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_inexact   <= 1'b0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
    end else if (take) begin
      out_valid     <= 1'b1;
      out_word      <= nxt_word;
      out_inexact   <= nxt_inx;
      out_overflow  <= nxt_ovf;
      out_underflow <= nxt_unf;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  AST_ACCEPT_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R1
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_inexact)
                                   && $stable(out_overflow) && $stable(out_underflow))); // R1
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> out_inexact); // R6
  AST_OVF_MAGNITUDE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_overflow) |-> (out_word[30:0] == 31'h7F80_0000 || out_word[30:0] == 31'h7F7F_FFFF)); // R6
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_underflow) |-> (out_inexact && !out_overflow)); // R7
  AST_JAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && neg_exp && in_sig != '0) |-> (jam != '0)); // R8
endmodule

// File: tb/f32_round_pack_test.sv
module f32_round_pack_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0, in_sign = 1'b0, out_ready = 1'b1;
  logic signed [9:0] in_exp = '0;
  logic [30:0]       in_sig = '0;
  logic [1:0]        in_mode = '0;
  logic              in_ready, out_valid, out_inexact, out_overflow, out_underflow;
  logic [31:0]       out_word;

  f32_round_pack uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_inexact(out_inexact), .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  typedef struct {
    logic [31:0] w;
    logic [2:0]  f;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0, rc = 0;
  bit   stall_en = 1'b0, finished = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(bit s, int e, longint unsigned sig, bit [1:0] m, string tag);
    longint unsigned inc, r, qv, w;
    exp_t t;
    bit dn = 1'b0;
    int n;
    t.tag = tag;
    inc = (m == 2'd0) ? 64 : (m == 2'd1) ? 0 : (m == 2'd2) ? (s ? 0 : 127) : (s ? 127 : 0);
    if (e > 253 || (e == 253 && sig + inc >= 64'h8000_0000)) begin
      t.w = {s, (inc == 0) ? 31'h7F7F_FFFF : 31'h7F80_0000};
      t.f = 3'b110;
      return t;
    end
    if (e < 0) begin
      n = -e;
      if (n >= 31) sig = (sig != 0) ? 1 : 0;
      else sig = (sig >> n) | (((sig & ((64'd1 << n) - 1)) != 0) ? 1 : 0);
      e = 0;
      dn = 1'b1;
    end
    r  = sig & 127;
    qv = (sig + inc) >> 7;
    if (m == 2'd0 && r == 64) qv = qv & ~64'd1;
    w = (longint'(s) << 31) + ((qv == 0) ? 64'd0 : (longint'(e) << 23)) + qv;
    t.w = w[31:0];
    t.f = {(r != 0), 1'b0, dn && (r != 0)};
    return t;
  endfunction

  task automatic send(bit s, int e, logic [30:0] sig, bit [1:0] m, string tag);
    bit done = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = e[9:0]; in_sig = sig; in_mode = m;
    while (!done) begin
      out_ready = stall_en ? ((rc % 3) == 0) : 1'b1;
      rc++;
      #1;
      if (in_ready) begin
        q.push_back(model(s, e, {33'b0, sig}, m, tag));
        done = 1'b1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor
  bit          was_stall = 1'b0;
  logic [34:0] held;
  always begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid) begin
      if (was_stall)
        chk({out_word, out_inexact, out_overflow, out_underflow} == held, "R1", "hold on stall",
            64'({out_word, out_inexact, out_overflow, out_underflow}), 64'(held));
      if (out_ready) begin
        was_stall = 1'b0;
        if (q.size() == 0) chk(1'b0, "R1", "unexpected output", 64'(out_word), 64'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(out_word == e.w, e.tag, "word", 64'(out_word), 64'(e.w));
          chk({out_inexact, out_overflow, out_underflow} == e.f, e.tag, "flags ixo/ovf/unf",
              64'({out_inexact, out_overflow, out_underflow}), 64'(e.f));
        end
      end else begin
        was_stall = 1'b1;
        held = {out_word, out_inexact, out_overflow, out_underflow};
      end
    end else was_stall = 1'b0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned x;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0 && out_word == 32'd0, "R11", "reset outputs", 64'({out_valid, out_word}), 64'd0);
    chk({out_inexact, out_overflow, out_underflow} == 3'b000, "R11", "reset flags",
        64'({out_inexact, out_overflow, out_underflow}), 64'd0);
    chk(in_ready == 1'b1, "R11", "reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R1 latency and R2 / R10 exact 1.0
    send(0, 126, 31'h4000_0000, 2'd0, "R2");
    #2;
    chk(out_valid == 1'b1, "R1", "out_valid one cycle after accept", 64'(out_valid), 64'd1);
    chk(out_word == 32'h3F80_0000, "R2", "1.0 packing literal", 64'(out_word), 64'h3F80_0000);
    chk(out_inexact == 1'b0, "R10", "exact value raises no inexact", 64'(out_inexact), 64'd0);
    send(0, 126, 31'h7FFF_FFC0, 2'd0, "R2");   // carry into exponent -> 2.0
    // R3 nearest-even
    send(0, 126, 31'h4000_0040, 2'd0, "R3");
    send(0, 126, 31'h4000_00C0, 2'd0, "R3");
    send(0, 126, 31'h4000_0041, 2'd0, "R3");
    // R4 toward zero
    send(0, 126, 31'h4000_007F, 2'd1, "R4");
    send(1, 126, 31'h4000_007F, 2'd1, "R4");
    // R5 directed
    send(0, 126, 31'h4000_0001, 2'd2, "R5");
    send(1, 126, 31'h4000_0001, 2'd2, "R5");
    send(1, 126, 31'h4000_0001, 2'd3, "R5");
    send(0, 126, 31'h4000_0001, 2'd3, "R5");
    // R6 overflow
    send(0, 254, 31'h4000_0000, 2'd0, "R6");
    send(0, 254, 31'h4000_0000, 2'd1, "R6");
    send(0, 253, 31'h7FFF_FFC0, 2'd0, "R6");
    send(0, 253, 31'h7FFF_FFC0, 2'd1, "R6");
    send(1, 300, 31'h4000_0000, 2'd2, "R6");
    // R7 denormalization
    send(0, -1, 31'h4000_0000, 2'd0, "R7");
    send(0, -3, 31'h4000_0041, 2'd0, "R7");
    send(0, -1, 31'h7FFF_FFFF, 2'd0, "R7");
    send(0, 0, 31'h0000_0081, 2'd0, "R7");
    // R8 sticky only
    send(0, -40, 31'h4000_0000, 2'd2, "R8");
    send(0, -40, 31'h4000_0000, 2'd0, "R8");
    send(1, -31, 31'h4000_0000, 2'd3, "R8");
    send(0, -512, 31'h0000_0000, 2'd2, "R8");
    // R9 zero exponent field
    send(0, 100, 31'h0000_003F, 2'd0, "R9");
    send(1, 100, 31'h0000_003F, 2'd0, "R9");

    // Randomized sweep under back-pressure
    stall_en = 1'b1;
    x = 32'h1234_5679;
    for (int i = 0; i < 60; i++) begin
      int unsigned y;
      x = x * 1664525 + 1013904223;
      y = x * 22695477 + 1;
      send(x[31], int'(x % 301) - 40, {1'b1, y[29:0]}, x[5:4], "R1");
    end
    stall_en = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1", "all results delivered", 64'(q.size()), 64'd0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule